// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the command front end of a parallel NOR-style flash memory. A host drives an asynchronous-style bus of chip enable, write enable, output enable, a 20-bit word address and 16-bit data. The controller turns multi-cycle write sequences into mode changes and array operations. It covers program, sector erase, erase suspend and resume, an identification (autoselect) read mode and an unlock-bypass fast program mode. Array reads need no command and pass straight through from the storage array, which sits outside the block.

Program and erase run for a fixed number of clock cycles, set by a parameter. Internal down-counters time them, and `busy` stays high for the whole run. When a program finishes, the block emits a one-cycle write request carrying the latched address and data. When an erase finishes, it emits a one-cycle erase request carrying the sector number, which is address bits 19..12. While an operation runs, reads return a polling status word. A per-sector protection mask blocks program and erase, and autoselect reads report it.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode: `busy`, `mem_we` and `ers_req` are 0, `rdata` is 0 when no read is active, and a read (ce_n=0, oe_n=0, we_n=1) returns `arr_rdata`.
- R2: The sequence AAh@555h, 55h@2AAh, A0h@any, then data@PA starts a program. `busy` is high for exactly PROG_CYC clocks. `mem_we` pulses once in the last busy clock with `mem_waddr`=PA and `mem_wdata`=data.
- R3: Polling reads return a status word with every bit 0 except bit 7. During a program, bit 7 is the inverse of bit 7 of the program data. During an erase the word is 0000h. While the erase is suspended, a read inside the erasing sector returns 0080h.
- R4: For command cycles only data bits 7..0 and address bits 10..0 are compared. A write cycle ends on the first rising edge of we_n or ce_n while both are low, and the address and data of the cycle are the values held at that moment.
- R5: After the unlock pair, 90h enters autoselect. Reads at address low byte 00h return MFR_CODE and at 01h return DEV_CODE. At 02h a read returns 0001h if the sector in address bits 19..12 is protected and 0000h if not. The mode stays until F0h is written.
- R6: A cycle that does not fit the expected sequence returns the machine to its base mode without any operation.
- R7: After the unlock pair, 20h enters bypass mode. There, A0h followed by one data cycle programs with no unlock. A0h without a prior bypass entry has no effect. Bypass is left with 90h then 00h, or with F0h.
- R8: Six cycles (AAh@555h, 55h@2AAh, 80h, AAh@555h, 55h@2AAh, 30h@SA) erase sector SA[19:12]. `busy` is high for ERASE_CYC running clocks, then `ers_req` pulses with `ers_sector`=SA[19:12].
- R9: B0h written during a sector erase suspends it: `busy` drops and the remaining count is held. 30h written while suspended resumes it. Total erase busy time stays ERASE_CYC. B0h during a program and 30h outside suspend have no effect.
- R10: While an erase is suspended, programs to other sectors run, and a program to the erasing sector is dropped. Reads of other sectors return array data. Autoselect can be entered, and F0h returns to the suspended state.
- R11: A program or erase aimed at a sector whose PROT_MASK bit is set raises no request and leaves `busy` low.
- R12: While a program runs, further write cycles are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| arr_rdata | input | DATA_W | Array word at `addr` from the storage model |
| rdata | output | DATA_W | Read data: array, status or identification |
| busy | output | 1 | Program or erase running |
| mem_we | output | 1 | One-cycle array write request |
| mem_waddr | output | ADDR_W | Program address |
| mem_wdata | output | DATA_W | Program data |
| ers_req | output | 1 | One-cycle sector erase request |
| ers_sector | output | ADDR_W-SECT_LSB | Sector to erase |

## Verification
The bench builds the block with PROG_CYC=5 and ERASE_CYC=24. This keeps whole runs short enough to count `busy` clocks exactly, across a suspend, a program inside the suspend and a resume. PROT_MASK sets sectors 3 and A5h, so protected and unprotected sectors sit side by side for autoselect reads and for blocked program and erase. The identification codes are set to 004Ah and 22C4h so that an autoselect read can never look like erased array data.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_ERA1, S_ERA2, S_ERA3,
    S_PGM_DATA, S_PGM_RUN, S_ERA_RUN, S_AUTO, S_BYP_EXIT
  } fsm_state_t;

  typedef enum logic [1:0] {B_READ, B_BYP, B_SUSP} base_mode_t;

  localparam logic [10:0] ADR_UNL_A   = 11'h555;
  localparam logic [10:0] ADR_UNL_B   = 11'h2AA;
  localparam logic [7:0]  CMD_UNL_A   = 8'hAA;
  localparam logic [7:0]  CMD_UNL_B   = 8'h55;
  localparam logic [7:0]  CMD_PROG    = 8'hA0;
  localparam logic [7:0]  CMD_ERSETUP = 8'h80;
  localparam logic [7:0]  CMD_ERSECT  = 8'h30;
  localparam logic [7:0]  CMD_RESUME  = 8'h30;
  localparam logic [7:0]  CMD_AUTOSEL = 8'h90;
  localparam logic [7:0]  CMD_BYPASS  = 8'h20;
  localparam logic [7:0]  CMD_SUSPEND = 8'hB0;
  localparam logic [7:0]  CMD_RESET   = 8'hF0;
  localparam logic [7:0]  CMD_BYPEXIT = 8'h00;

endpackage

// File: rtl/flash_bus_strobe.sv
module flash_bus_strobe #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_act
);
  logic act, act_q;

  // a write cycle is live while both strobes are low
  assign act    = ~ce_n & ~we_n;
  assign rd_act = ~ce_n & ~oe_n & we_n;
  // the first strobe to rise ends the cycle
  assign wr_evt = act_q & ~act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      wr_data <= '0;
    end else if (act) begin
      wr_addr <= addr;
      wr_data <= wdata;
    end
  end

  // R4
  single_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  input  logic             hold,
  output logic             run,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_d;

  assign run  = run_q_w;
  logic run_q_w;
  assign done = run_q_w & ~hold & (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q_w;
    if (start) begin
      cnt_d = len;
      run_d = 1'b1;
    end else if (run_q_w && !hold) begin
      if (done) run_d = 1'b0;
      else      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      run_q_w <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      run_q_w <= run_d;
    end
  end

  // R2
  load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q_w) |-> cnt_q == $past(len));

  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q_w && hold && !start) |=> $stable(cnt_q));

  // R2
  stop_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !run_q_w);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int SECT_LSB  = 12,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 64,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h004A,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h22C4,
  parameter logic [(1<<(ADDR_W-SECT_LSB))-1:0] PROT_MASK = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ce_n,
  input  logic                       we_n,
  input  logic                       oe_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [DATA_W-1:0]          arr_rdata,
  output logic [DATA_W-1:0]          rdata,
  output logic                       busy,
  output logic                       mem_we,
  output logic [ADDR_W-1:0]          mem_waddr,
  output logic [DATA_W-1:0]          mem_wdata,
  output logic                       ers_req,
  output logic [ADDR_W-SECT_LSB-1:0] ers_sector
);
  localparam int SECT_W = ADDR_W - SECT_LSB;
  localparam int MAXC   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic              wr_evt, rd_act;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  flash_bus_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_s), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_act(rd_act));

  fsm_state_t        state_q, state_d;
  base_mode_t        base_q, base_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [DATA_W-1:0] pd_q, pd_d;
  logic [SECT_W-1:0] es_q, es_d;
  logic              prog_go, era_go, prog_done, era_done, prog_run, era_run;

  flash_op_timer #(.CNT_W(CNT_W)) u_prog_tmr (
    .clk(clk), .rst_n(rst_s), .start(prog_go), .len(CNT_W'(PROG_CYC)),
    .hold(1'b0), .run(prog_run), .done(prog_done));

  flash_op_timer #(.CNT_W(CNT_W)) u_era_tmr (
    .clk(clk), .rst_n(rst_s), .start(era_go), .len(CNT_W'(ERASE_CYC)),
    .hold(state_q != S_ERA_RUN), .run(era_run), .done(era_done));

  logic [7:0]        cmd;
  logic [10:0]       cadr;
  logic [SECT_W-1:0] wr_sect, rd_sect;
  logic              unl_a, unl_b, prot_wr;

  assign cmd     = wr_data[7:0];
  assign cadr    = wr_addr[10:0];
  assign wr_sect = wr_addr[ADDR_W-1:SECT_LSB];
  assign rd_sect = addr[ADDR_W-1:SECT_LSB];
  assign unl_a   = (cmd == CMD_UNL_A) && (cadr == ADR_UNL_A);
  assign unl_b   = (cmd == CMD_UNL_B) && (cadr == ADR_UNL_B);
  assign prot_wr = PROT_MASK[wr_sect];

  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    pa_d    = pa_q;
    pd_d    = pd_q;
    es_d    = es_q;
    prog_go = 1'b0;
    era_go  = 1'b0;
    mem_we  = 1'b0;
    ers_req = 1'b0;
    case (state_q)
      S_PGM_RUN: if (prog_done) begin
        mem_we  = 1'b1;
        state_d = S_IDLE;
      end
      S_ERA_RUN: if (era_done) begin
        ers_req = 1'b1;
        state_d = S_IDLE;
        base_d  = B_READ;
      end else if (wr_evt && cmd == CMD_SUSPEND) begin
        state_d = S_IDLE;
        base_d  = B_SUSP;
      end
      S_PGM_DATA: if (wr_evt) begin
        pa_d = wr_addr;
        pd_d = wr_data;
        if (prot_wr || (base_q == B_SUSP && wr_sect == es_q)) begin
          state_d = S_IDLE;
        end else begin
          state_d = S_PGM_RUN;
          prog_go = 1'b1;
        end
      end
      default: if (wr_evt) begin
        if (cmd == CMD_RESET) begin
          state_d = S_IDLE;
          if (base_q == B_BYP) base_d = B_READ;
        end else begin
          case (state_q)
            S_IDLE: case (base_q)
              B_BYP: begin
                if (cmd == CMD_PROG)         state_d = S_PGM_DATA;
                else if (cmd == CMD_AUTOSEL) state_d = S_BYP_EXIT;
              end
              B_SUSP: begin
                if (cmd == CMD_RESUME) begin
                  state_d = S_ERA_RUN;
                  base_d  = B_READ;
                end else if (unl_a) state_d = S_UNL1;
              end
              default: if (unl_a) state_d = S_UNL1;
            endcase
            S_UNL1: state_d = unl_b ? S_UNL2 : S_IDLE;
            S_UNL2: begin
              state_d = S_IDLE;
              if (cmd == CMD_PROG)         state_d = S_PGM_DATA;
              else if (cmd == CMD_AUTOSEL) state_d = S_AUTO;
              else if (base_q == B_READ && cmd == CMD_ERSETUP) state_d = S_ERA1;
              else if (base_q == B_READ && cmd == CMD_BYPASS)  base_d  = B_BYP;
            end
            S_ERA1: state_d = unl_a ? S_ERA2 : S_IDLE;
            S_ERA2: state_d = unl_b ? S_ERA3 : S_IDLE;
            S_ERA3: begin
              state_d = S_IDLE;
              if (cmd == CMD_ERSECT && !prot_wr) begin
                es_d    = wr_sect;
                state_d = S_ERA_RUN;
                era_go  = 1'b1;
              end
            end
            S_BYP_EXIT: begin
              state_d = S_IDLE;
              if (cmd == CMD_BYPEXIT) base_d = B_READ;
            end
            default: state_d = state_q;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= S_IDLE;
      base_q  <= B_READ;
      pa_q    <= '0;
      pd_q    <= '0;
      es_q    <= '0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      if (prog_go || state_q == S_PGM_DATA) begin
        pa_q <= pa_d;
        pd_q <= pd_d;
      end
      if (era_go) es_q <= es_d;
    end
  end

  assign busy       = (state_q == S_PGM_RUN) || (state_q == S_ERA_RUN);
  assign mem_waddr  = pa_q;
  assign mem_wdata  = pd_q;
  assign ers_sector = es_q;

  always_comb begin
    rdata = '0;
    if (rd_act) begin
      if (state_q == S_PGM_RUN) begin
        rdata[7] = ~pd_q[7];
      end else if (state_q == S_ERA_RUN) begin
        rdata = '0;
      end else if (state_q == S_AUTO) begin
        case (addr[7:0])
          8'h00:   rdata = MFR_CODE;
          8'h01:   rdata = DEV_CODE;
          8'h02:   rdata = DATA_W'(PROT_MASK[rd_sect]);
          default: rdata = '0;
        endcase
      end else if (base_q == B_SUSP && rd_sect == es_q) begin
        rdata[7] = 1'b1;
      end else begin
        rdata = arr_rdata;
      end
    end
  end

  // R2
  we_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_s)
    mem_we |=> !busy);

  // R11
  no_prot_write_chk: assert property (@(posedge clk) disable iff (!rst_s)
    mem_we |-> !PROT_MASK[mem_waddr[ADDR_W-1:SECT_LSB]]);

  // R9
  susp_not_running_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (base_q == B_SUSP) |-> (state_q != S_ERA_RUN && !ers_req));

  // R10
  susp_other_sect_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_we && base_q == B_SUSP) |-> (mem_waddr[ADDR_W-1:SECT_LSB] != es_q));

  // R7
  byp_exit_in_byp_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == S_BYP_EXIT) |-> (base_q == B_BYP));

  // R8
  erase_req_timer_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ers_req |-> era_run);

  // R2
  prog_req_timer_chk: assert property (@(posedge clk) disable iff (!rst_s)
    mem_we |-> prog_run);

endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int PC = 5;
  localparam int EC = 24;
  localparam logic [255:0] PMASK = (256'd1 << 3) | (256'd1 << 165);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] arr_rdata, rdata, mem_wdata;
  logic [AW-1:0] mem_waddr;
  logic busy, mem_we, ers_req;
  logic [7:0] ers_sector;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SECT_LSB(12), .PROG_CYC(PC),
    .ERASE_CYC(EC), .MFR_CODE(16'h004A), .DEV_CODE(16'h22C4), .PROT_MASK(PMASK)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .arr_rdata(arr_rdata), .rdata(rdata),
    .busy(busy), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .ers_req(ers_req), .ers_sector(ers_sector));

  // behavioural array: index {sector[3:0], word[3:0]}
  logic [DW-1:0] ram [256];
  assign arr_rdata = ram[{addr[15:12], addr[3:0]}];

  logic clr = 1'b0;
  int busy_cnt, we_cnt, ers_cnt;
  logic [AW-1:0] last_wa;
  logic [7:0] last_es;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) ram[i] <= 16'hFFFF;
    end else begin
      if (mem_we) ram[{mem_waddr[15:12], mem_waddr[3:0]}] <= mem_wdata;
      if (ers_req) for (int i = 0; i < 16; i++) ram[{ers_sector[3:0], i[3:0]}] <= 16'hFFFF;
    end
    if (clr) begin
      busy_cnt <= 0; we_cnt <= 0; ers_cnt <= 0;
    end else begin
      if (busy)    busy_cnt <= busy_cnt + 1;
      if (mem_we)  begin we_cnt <= we_cnt + 1; last_wa <= mem_waddr; end
      if (ers_req) begin ers_cnt <= ers_cnt + 1; last_es <= ers_sector; end
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    #1 chk(tag, 32'(rdata), 32'(exp));
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic unlock();
    wr(20'h00555, 16'h00AA);
    wr(20'h002AA, 16'h0055);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_I = 2'd2;
  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } vec_t;
  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{OP_R, 20'h01002, 16'hFFFF},  // R1 plain array read
    '{OP_W, 20'hAB555, 16'h77AA},  // R4 upper bits ignored
    '{OP_W, 20'hFF2AA, 16'h1255},  // R4
    '{OP_W, 20'h00555, 16'h0090},  // R5 autoselect entry
    '{OP_R, 20'h00000, 16'h004A},  // R5
    '{OP_R, 20'h00001, 16'h22C4},  // R5
    '{OP_R, 20'h03002, 16'h0001},  // R5 protected sector
    '{OP_R, 20'h04002, 16'h0000},  // R5 open sector
    '{OP_W, 20'h00000, 16'h00F0},  // R5 leave
    '{OP_R, 20'h01002, 16'hFFFF},  // R5 back to array
    '{OP_W, 20'h00555, 16'h00AA},  // R6
    '{OP_W, 20'h002AA, 16'h0055},  // R6
    '{OP_W, 20'h00555, 16'h0012},  // R6 junk command
    '{OP_R, 20'h00000, 16'hFFFF},  // R6 array, not autoselect
    '{OP_W, 20'h00555, 16'h00A0},  // R7 A0 outside bypass
    '{OP_W, 20'h02004, 16'h1234},  // R7
    '{OP_R, 20'h02004, 16'hFFFF},  // R7 nothing written
    '{OP_W, 20'h00555, 16'h00AA},  // R7 enter bypass
    '{OP_W, 20'h002AA, 16'h0055},
    '{OP_W, 20'h00555, 16'h0020},
    '{OP_W, 20'h00000, 16'h00A0},  // R7 bypass program
    '{OP_W, 20'h02004, 16'h1234},
    '{OP_I, 20'h00000, 16'h0000},
    '{OP_R, 20'h02004, 16'h1234},  // R7
    '{OP_W, 20'h00000, 16'h00A0},
    '{OP_W, 20'h02005, 16'h0F0F},
    '{OP_I, 20'h00000, 16'h0000},
    '{OP_R, 20'h02005, 16'h0F0F},  // R7
    '{OP_W, 20'h00000, 16'h0090},  // R7 bypass exit
    '{OP_W, 20'h00000, 16'h0000},
    '{OP_W, 20'h00000, 16'h00A0},  // R7 A0 no longer accepted
    '{OP_W, 20'h02006, 16'h5555},
    '{OP_R, 20'h02006, 16'hFFFF}   // R7
  };

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog got=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    clear();
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 mem_we", 32'(mem_we), 0);
    chk("R1 ers_req", 32'(ers_req), 0);
    chk("R1 rdata idle", 32'(rdata), 0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_W:    wr(VEC[i].a, VEC[i].d);
        OP_R:    rd(VEC[i].a, VEC[i].d, $sformatf("table[%0d]", i));
        default: wait_idle();
      endcase
    end

    // R2 / R3 program timing and polling; R12 writes ignored while busy
    clear();
    unlock(); wr(20'h00555, 16'h00A0); wr(20'h05001, 16'h5A3C);
    chk("R2 busy started", 32'(busy), 1);
    rd(20'h05001, 16'h0080, "R3 program poll");
    wr(20'h00000, 16'h00B0);
    wait_idle();
    chk("R2 busy cycles", 32'(busy_cnt), PC);
    chk("R2 one write", 32'(we_cnt), 1);
    chk("R2 address", 32'(last_wa), 32'h05001);
    rd(20'h05001, 16'h5A3C, "R12 data");

    // R4 chip enable rises first, later bus changes are not captured
    clear();
    unlock(); wr(20'h00555, 16'h00A0);
    @(negedge clk); addr = 20'h06003; wdata = 16'h0A0A; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); addr = 20'h06009; wdata = 16'hDEAD;
    @(negedge clk); we_n = 1'b1;
    wait_idle();
    chk("R4 address", 32'(last_wa), 32'h06003);
    rd(20'h06003, 16'h0A0A, "R4 data");

    // R8 sector erase
    clear();
    unlock(); wr(20'h00555, 16'h0080); unlock(); wr(20'h06000, 16'h0030);
    rd(20'h06003, 16'h0000, "R3 erase poll");
    wait_idle();
    chk("R8 busy cycles", 32'(busy_cnt), EC);
    chk("R8 one erase", 32'(ers_cnt), 1);
    chk("R8 sector", 32'(last_es), 6);
    rd(20'h06003, 16'hFFFF, "R8 erased");

    // R9 / R10 suspend and resume
    unlock(); wr(20'h00555, 16'h00A0); wr(20'h07001, 16'h1111); wait_idle();
    clear();
    unlock(); wr(20'h00555, 16'h0080); unlock(); wr(20'h07000, 16'h0030);
    repeat (4) @(negedge clk);
    wr(20'h00000, 16'h00B0);
    chk("R9 suspended busy", 32'(busy), 0);
    rd(20'h07001, 16'h0080, "R3 suspend poll");
    rd(20'h05001, 16'h5A3C, "R10 other sector read");
    unlock(); wr(20'h00555, 16'h00A0); wr(20'h05002, 16'h2222); wait_idle();
    rd(20'h05002, 16'h2222, "R10 program in suspend");
    unlock(); wr(20'h00555, 16'h00A0); wr(20'h07002, 16'h3333);
    chk("R10 erasing sector blocked", 32'(busy), 0);
    chk("R10 write count", 32'(we_cnt), 1);
    unlock(); wr(20'h00555, 16'h0090);
    rd(20'h03002, 16'h0001, "R10 autoselect in suspend");
    wr(20'h00000, 16'h00F0);
    rd(20'h07001, 16'h0080, "R10 back to suspend");
    wr(20'h00000, 16'h0030);
    chk("R9 resumed", 32'(busy), 1);
    wait_idle();
    chk("R9 total busy", 32'(busy_cnt), EC + PC);
    chk("R9 erase sector", 32'(last_es), 7);
    rd(20'h07001, 16'hFFFF, "R9 erased after resume");
    wr(20'h00000, 16'h0030);
    chk("R9 resume outside suspend", 32'(busy), 0);

    // R11 protected sector
    clear();
    unlock(); wr(20'h00555, 16'h00A0); wr(20'h03001, 16'h0000);
    chk("R11 program busy", 32'(busy), 0);
    unlock(); wr(20'h00555, 16'h0080); unlock(); wr(20'h03000, 16'h0030);
    chk("R11 erase busy", 32'(busy), 0);
    repeat (3) @(negedge clk);
    chk("R11 no requests", 32'(we_cnt + ers_cnt), 0);
    rd(20'h03001, 16'hFFFF, "R11 data kept");

    summary();
    $finish;
  end
endmodule